// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the targets of subroutine returns for an instruction fetch unit. When fetch sees a call, it raises `push_en` and gives the call's address on `call_pc`. The block saves `call_pc + 4` as the return address on a small last-in-first-out stack. When fetch sees a return, it raises `pop_en`. The block removes the newest saved address and presents it on `pred_target` in the next cycle. `pred_valid` says whether a live call backed that prediction.

The storage is a shift register of `DEPTH` slots, with slot 0 as the newest.

- **Push:** every slot moves one place deeper. When the stack is already full, the oldest address falls off the end.
- **Pop:** every slot moves one place shallower. The deepest slot keeps its own value, so it ends up duplicated.
- **Underflow:** popping more times than there were pushes still returns a plausible old address, never undefined data.

A small state machine tracks how many live entries the stack holds. Its states are `RAS_EMPTY`, `RAS_PARTIAL` and `RAS_FULL`. The occupancy count behind them never goes below zero and never goes above `DEPTH`. The decoded operation drives the transitions:

| From | Operation | To |
|---|---|---|
| `RAS_EMPTY` | push or swap | `RAS_PARTIAL` |
| `RAS_EMPTY` | pop | stays `RAS_EMPTY` |
| `RAS_PARTIAL` | push at `DEPTH-1` live entries | `RAS_FULL` |
| `RAS_PARTIAL` | pop at one live entry | `RAS_EMPTY` |
| `RAS_FULL` | pop | `RAS_PARTIAL` |
| any state | push when full, swap at non-zero count, or idle | stays in the same state |

A "swap" is a push and a pop in the same cycle.

Top module: `ras_predictor`

## Requirements
- R1: A push stores `call_pc + 4` (modulo 2^ADDR_W) as the newest entry. A later pop with no intervening operation presents that value on `pred_target` in the cycle after the pop edge, with `pred_valid` = 1.
- R2: Nested pushes come back in last-in-first-out order. Pushes from calls at X and then Y give pops of Y+4 first and then X+4.
- R3: The stack holds `DEPTH` entries (4 to 8, default 8). A push while `DEPTH` entries are live discards the oldest entry. The occupancy count never exceeds `DEPTH`.
- R4: A pop leaves the deepest slot unchanged. Pops beyond the live entries therefore present the last surviving deepest address again and again.
- R5: After reset, `pred_target` is 0 and `pred_valid` is 0. A pop before any push presents target 0 with `pred_valid` = 0.
- R6: A push and a pop in the same cycle present the old newest entry as the prediction and overwrite the newest slot with `call_pc + 4`. The other slots are left untouched. The count is unchanged, or becomes 1 if it was 0.
- R7: `pred_valid` is 1 only in the cycle after a pop edge. In cycles not preceded by a pop, `pred_valid` is 0 and `pred_target` holds its last value.
- R8: The occupancy count saturates at zero. A pop at count 0 gives `pred_valid` = 0 and leaves the count at 0, so one later push followed by one pop gives `pred_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_en | input | 1 | A call was fetched this cycle |
| call_pc | input | ADDR_W | Address of the call instruction |
| pop_en | input | 1 | A return was fetched this cycle |
| pred_target | output | ADDR_W | Predicted return address, registered |
| pred_valid | output | 1 | One-cycle flag: the prediction came from a live entry |

## Verification
The assertions assume the following about the inputs:

- `push_en`, `pop_en` and `call_pc` carry known values at every rising edge.
- They change only away from that edge.
- `pop_en` is low while `rst_n` is asserted, so the first cycle after reset is not seen as following a pop.
- The return address is taken to wrap modulo 2^ADDR_W.

The stimulus respects all of this. It changes inputs only on falling edges and holds both enables low through reset. Its call addresses are well below the top of the address space, so the +4 step never wraps.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } ras_op_e;

    typedef enum logic [1:0] {
        RAS_EMPTY   = 2'd0,
        RAS_PARTIAL = 2'd1,
        RAS_FULL    = 2'd2
    } ras_state_e;

    function automatic logic op_reads_top(input ras_op_e op);
        return (op == OP_POP) || (op == OP_SWAP);
    endfunction

endpackage

// File: rtl/ras_op_decode.sv
module ras_op_decode
    import ras_pkg::*;
(
    input  logic    push_en,
    input  logic    pop_en,
    output ras_op_e op
);

    always_comb begin
        unique case ({push_en, pop_en})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_IDLE;
        endcase
    end

endmodule

// File: rtl/ras_occupancy_fsm.sv
module ras_occupancy_fsm
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ras_op_e          op,
    output logic [CNT_W-1:0] count,
    output ras_state_e       state,
    output logic             live
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ras_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;

    // Next-state and next-count logic
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            RAS_EMPTY: begin
                if (op == OP_PUSH || op == OP_SWAP) begin
                    count_d = CNT_ONE;
                    state_d = (DEPTH == 1) ? RAS_FULL : RAS_PARTIAL;
                end
            end
            RAS_PARTIAL: begin
                unique case (op)
                    OP_PUSH: begin
                        count_d = count_q + CNT_ONE;
                        if (count_q == CNT_MAX - CNT_ONE) state_d = RAS_FULL;
                    end
                    OP_POP: begin
                        count_d = count_q - CNT_ONE;
                        if (count_q == CNT_ONE) state_d = RAS_EMPTY;
                    end
                    default: ;
                endcase
            end
            RAS_FULL: begin
                if (op == OP_POP) begin
                    count_d = count_q - CNT_ONE;
                    state_d = (DEPTH == 1) ? RAS_EMPTY : RAS_PARTIAL;
                end
            end
            default: begin
                state_d = RAS_EMPTY;
                count_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RAS_EMPTY;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // Outputs
    always_comb begin
        state = state_q;
        count = count_q;
        live  = (state_q != RAS_EMPTY);
    end

endmodule

// File: rtl/ras_entry_stack.sv
module ras_entry_stack
    import ras_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ras_op_e           op,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic [ADDR_W-1:0] top,
    output logic [ADDR_W-1:0] bottom
);

    logic [ADDR_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [ADDR_W-1:0] shallower;
        logic [ADDR_W-1:0] deeper;

        if (i == 0) begin : g_first
            assign shallower = ret_addr;
        end else begin : g_inner_s
            assign shallower = slot[i-1];
        end

        if (i == DEPTH - 1) begin : g_last
            assign deeper = slot[i];
        end else begin : g_inner_d
            assign deeper = slot[i+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else begin
                unique case (op)
                    OP_PUSH: slot[i] <= shallower;
                    OP_POP:  slot[i] <= deeper;
                    OP_SWAP: if (i == 0) slot[i] <= ret_addr;
                    default: ;
                endcase
            end
        end
    end

    assign top    = slot[0];
    assign bottom = slot[DEPTH-1];

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int ADDR_W   = 32,
    parameter int RET_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] call_pc,
    input  logic              pop_en,
    output logic [ADDR_W-1:0] pred_target,
    output logic              pred_valid
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    ras_op_e           op;
    ras_state_e        occ_state;
    logic [CNT_W-1:0]  occ_count;
    logic              occ_live;
    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] stk_top;
    logic [ADDR_W-1:0] stk_bottom;

    assign ret_addr = call_pc + ADDR_W'(RET_STEP);

    ras_op_decode u_dec (
        .push_en (push_en),
        .pop_en  (pop_en),
        .op      (op)
    );

    ras_occupancy_fsm #(.DEPTH(DEPTH)) u_occ (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .count (occ_count),
        .state (occ_state),
        .live  (occ_live)
    );

    ras_entry_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .ret_addr (ret_addr),
        .top      (stk_top),
        .bottom   (stk_bottom)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_target <= '0;
            pred_valid  <= 1'b0;
        end else if (op_reads_top(op)) begin
            pred_target <= stk_top;
            pred_valid  <= occ_live;
        end else begin
            pred_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_en,
    input logic              pop_en,
    input logic [ADDR_W-1:0] call_pc,
    input logic [ADDR_W-1:0] pred_target,
    input logic              pred_valid,
    input logic [ADDR_W-1:0] top,
    input logic [ADDR_W-1:0] bottom,
    input logic [CNT_W-1:0]  count
);

    assert_push_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (top == $past(call_pc) + ADDR_W'(4)));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_bottom_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en) |=> $stable(bottom));

    assert_swap_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en) |=> (pred_target == $past(top)));

    assert_valid_after_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_en |=> !pred_valid);

    assert_target_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_en |=> $stable(pred_target));

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop_en && !push_en) |=> (count == '0 && !pred_valid));

endmodule

bind ras_predictor ras_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_en     (push_en),
    .pop_en      (pop_en),
    .call_pc     (call_pc),
    .pred_target (pred_target),
    .pred_valid  (pred_valid),
    .top         (stk_top),
    .bottom      (stk_bottom),
    .count       (occ_count)
);

// File: tb/ras_predictor_tb.sv
module ras_predictor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int ADDR_W     = 32;
    localparam int WATCHDOG   = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_en = 1'b0;
    logic              pop_en = 1'b0;
    logic [ADDR_W-1:0] call_pc = '0;
    logic [ADDR_W-1:0] pred_target;
    logic              pred_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ras_predictor #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_en     (push_en),
        .call_pc     (call_pc),
        .pop_en      (pop_en),
        .pred_target (pred_target),
        .pred_valid  (pred_valid)
    );

    // Reference model, written from the requirements
    logic [ADDR_W-1:0] mdl [DEPTH];
    int                mcnt = 0;

    // Scoreboard queues
    logic [ADDR_W-1:0] q_tgt [$];
    bit                q_vld [$];
    string             q_tag [$];

    task automatic check(input string tag, input logic [ADDR_W-1:0] got_t, input bit got_v,
                         input logic [ADDR_W-1:0] exp_t, input bit exp_v);
        n_checks++;
        if (got_t !== exp_t || got_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: target=%h valid=%0b expected target=%h valid=%0b",
                     tag, got_t, got_v, exp_t, exp_v);
        end
    endtask

    task automatic step(input bit pu, input bit po, input logic [ADDR_W-1:0] pc, input string tag);
        @(negedge clk);
        push_en = pu;
        pop_en  = po;
        call_pc = pc;
        if (po) begin
            q_tgt.push_back(mdl[0]);
            q_vld.push_back(mcnt > 0);
            q_tag.push_back(tag);
        end
        if (pu && po) begin
            mdl[0] = pc + 4;
            if (mcnt == 0) mcnt = 1;
        end else if (pu) begin
            for (int i = DEPTH - 1; i > 0; i--) mdl[i] = mdl[i-1];
            mdl[0] = pc + 4;
            if (mcnt < DEPTH) mcnt++;
        end else if (po) begin
            for (int i = 0; i < DEPTH - 1; i++) mdl[i] = mdl[i+1];
            if (mcnt > 0) mcnt--;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0, "R7");
    endtask

    // Monitor
    bit                pop_seen = 1'b0;
    logic [ADDR_W-1:0] last_tgt = '0;

    always @(posedge clk) pop_seen <= pop_en;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pop_seen) begin
                if (q_tgt.size() == 0) begin
                    check("R7 unexpected pop", pred_target, pred_valid, last_tgt, 1'b0);
                end else begin
                    logic [ADDR_W-1:0] et;
                    bit                ev;
                    string             tg;
                    et = q_tgt.pop_front();
                    ev = q_vld.pop_front();
                    tg = q_tag.pop_front();
                    check(tg, pred_target, pred_valid, et, ev);
                    last_tgt = et;
                end
            end else begin
                // R7: no pop at the previous edge -> flag low, target held
                check("R7", pred_target, pred_valid, last_tgt, 1'b0);
            end
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R5: reset state
        check("R5 reset", pred_target, pred_valid, '0, 1'b0);
        rst_n = 1'b1;
        idle(2);

        // R5 / R8: pop before any push
        step(0, 1, '0, "R5");
        idle(1);

        // R1: single call/return
        step(1, 0, 32'h0000_1000, "R1");
        step(0, 1, '0, "R1");
        idle(2);

        // R2: nested calls
        step(1, 0, 32'h0000_2000, "R2");
        step(1, 0, 32'h0000_3000, "R2");
        step(0, 1, '0, "R2");
        step(0, 1, '0, "R2");

        // R4 / R8: underflow gives stale bottom, not valid
        step(0, 1, '0, "R4");
        step(0, 1, '0, "R4");
        idle(1);

        // R3: overfill by one, then drain
        for (int k = 0; k < DEPTH + 1; k++) step(1, 0, 32'h0001_0000 + 32'(k) * 32'h100, "R3");
        for (int k = 0; k < DEPTH + 2; k++) step(0, 1, '0, "R3");
        idle(1);

        // R8: saturation at zero, then one push and one pop
        step(0, 1, '0, "R8");
        step(1, 0, 32'h0000_5000, "R8");
        step(0, 1, '0, "R8");
        step(0, 1, '0, "R8");
        idle(1);

        // R6: simultaneous push and pop
        step(1, 0, 32'h0000_6000, "R6");
        step(1, 1, 32'h0000_7000, "R6");
        step(0, 1, '0, "R6");
        step(0, 1, '0, "R6");
        // R6 at count zero
        step(1, 1, 32'h0000_8000, "R6");
        step(0, 1, '0, "R6");
        idle(3);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got cycles=%0d expected below %0d",
                     cyc, WATCHDOG);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule